// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a simple single-word request port inside the chip and an external asynchronous static RAM of 131,072 words by 16 bits. Each request is either a read or a write. It carries a 17-bit word address, 16 bits of write data and a two-bit active-low byte mask. The controller turns each request into a sequence of registered, active-low strobes: chip select, write strobe, output enable and one enable per byte lane. It returns a one-cycle response pulse when the sequence is finished.

All strobe timing is counted in whole clock cycles. The counts come from parameters that hold the clock period and the RAM's minimum pulse and access times, and each time is rounded up. The bidirectional data bus is modelled as three signals: an output word, an input word and a drive enable. The controller never drives the bus while the RAM may be driving it. It inserts one dead cycle before it drives the bus after a read. The address only changes while every strobe is inactive.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every strobe is high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only when `req_ready` is high. `req_ready` stays low from the accepting edge until one cycle after the response pulse, and it is never high while any strobe is low or the bus is driven.
- R3: A write with at least one lane enabled runs in three parts. First comes one setup cycle with the data driven and all strobes high. Next, chip select and write strobe are both low for exactly WP cycles, where WP is the largest of the rounded-up write pulse, address-to-end and data-setup times. Last comes one recovery cycle with the strobes high and the data still driven. The response arrives WP+2 cycles after acceptance.
- R4: Mask bit 0 controls the lower lane (data bits 7:0, `sram_lb_n`) and mask bit 1 controls the upper lane (bits 15:8, `sram_ub_n`). A lane strobe is low only while chip select is low and its mask bit is 0. A lane with mask bit 1 keeps its stored byte.
- R5: A read with at least one lane enabled drives chip select and output enable low with the write strobe high for exactly AA cycles. AA is the largest of the rounded-up address, chip-select, output-enable and byte-enable access times. The bus word is captured at the last of those edges, and the response arrives AA cycles after acceptance.
- R6: In a read response, every lane whose mask bit is 1 returns zero, whatever the bus carries.
- R7: A request whose mask is 2'b11 toggles no strobe, and its response arrives on the cycle right after the accepting edge, with zero data.
- R8: The address output changes only at an edge before which chip select, write strobe and both lane strobes were all high.
- R9: Output enable is high for the whole of every write. The drive enable is never high while output enable is low. A write that follows a bus read spends one extra turnaround cycle before driving, so its response comes at WP+3. Output enable has been high for at least two cycles whenever the drive enable rises.
- R10: `rsp_valid` is a single-cycle pulse, and a write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be_n | input | 2 | Active-low lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| sram_addr | output | 17 | RAM address |
| sram_dq_out | output | 16 | Data driven to the RAM |
| sram_dq_in | input | 16 | Data seen on the RAM bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower lane enable, active low |
| sram_ub_n | output | 1 | Upper lane enable, active low |

## Verification
A wrong sequencer state or a wrong cycle count shows up at the strobe pins on the very cycle it goes wrong. It appears as a write or read strobe of the wrong length, a lane strobe that does not match the mask, or a drive enable that overlaps output enable. It also shifts the response pulse away from its expected latency for that request. A capture or masking fault shows up only in the response data, so each write is read back later through the same port. The bench also expects a fixed filler byte in disabled lanes to come back as zero.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WSTB,
        ST_WREC,
        ST_RACC
    } ctl_state_e;

    // cycles needed to cover t_ps at clk_ps, rounded up
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_lane.sv
`timescale 1ns/1ps
module sram_ctrl_lane #(
    parameter int LANE_W = 8
) (
    input  logic              lane_off,
    input  logic [LANE_W-1:0] bus_byte,
    output logic [LANE_W-1:0] cap_byte
);
    // a lane that was not enabled returns zero
    always_comb cap_byte = lane_off ? '0 : bus_byte;
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int LANE_W   = 8,
    parameter int CLK_PS   = 10000,
    parameter int T_WP_PS  = 8000,
    parameter int T_AW_PS  = 8000,
    parameter int T_DW_PS  = 6000,
    parameter int T_AA_PS  = 10000,
    parameter int T_ACE_PS = 10000,
    parameter int T_OE_PS  = 5000,
    parameter int T_BA_PS  = 5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]          req_be_n,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [2*LANE_W-1:0] sram_dq_out,
    input  logic [2*LANE_W-1:0] sram_dq_in,
    output logic                sram_dq_oe,
    output logic                sram_ce_n,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic                sram_lb_n,
    output logic                sram_ub_n
);
    localparam int NLANE  = 2;
    localparam int DATA_W = NLANE * LANE_W;

    localparam int WP_RAW = max_of(max_of(cycles_for(T_WP_PS, CLK_PS),
                                          cycles_for(T_AW_PS, CLK_PS)),
                                   cycles_for(T_DW_PS, CLK_PS));
    localparam int AA_RAW = max_of(max_of(cycles_for(T_AA_PS, CLK_PS),
                                          cycles_for(T_ACE_PS, CLK_PS)),
                                   max_of(cycles_for(T_OE_PS, CLK_PS),
                                          cycles_for(T_BA_PS, CLK_PS)));
    localparam int WP_CYC = max_of(WP_RAW, 1);
    localparam int AA_CYC = max_of(AA_RAW, 1);
    localparam int CNT_W  = max_of($clog2(max_of(WP_CYC, AA_CYC) + 1), 1);

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [NLANE-1:0]  be_n;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [NLANE-1:0]  lane_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rsp_valid;
        logic              rd_turn;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic [DATA_W-1:0] cap_word;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        sram_ctrl_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_off (r_q.be_n[g]),
            .bus_byte (sram_dq_in[g*LANE_W +: LANE_W]),
            .cap_byte (cap_word[g*LANE_W +: LANE_W])
        );
    end

    assign req_ready = (r_q.state == ST_IDLE) && !r_q.rsp_valid;

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be_n  = req_be_n;
                    if (&req_be_n) begin
                        r_d.rdata     = '0;
                        r_d.rsp_valid = 1'b1;
                    end else if (req_write) begin
                        r_d.rdata   = '0;
                        r_d.rd_turn = 1'b0;
                        if (r_q.rd_turn) begin
                            r_d.state = ST_TURN;
                        end else begin
                            r_d.state = ST_WSET;
                            r_d.dq_oe = 1'b1;
                        end
                    end else begin
                        r_d.state  = ST_RACC;
                        r_d.ce_n   = 1'b0;
                        r_d.oe_n   = 1'b0;
                        r_d.lane_n = req_be_n;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(AA_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                r_d.state = ST_WSET;
                r_d.dq_oe = 1'b1;
            end
            ST_WSET: begin
                r_d.state  = ST_WSTB;
                r_d.ce_n   = 1'b0;
                r_d.we_n   = 1'b0;
                r_d.lane_n = r_q.be_n;
                tmr_load   = 1'b1;
                tmr_val    = CNT_W'(WP_CYC - 1);
            end
            ST_WSTB: begin
                if (tmr_done) begin
                    r_d.state  = ST_WREC;
                    r_d.ce_n   = 1'b1;
                    r_d.we_n   = 1'b1;
                    r_d.lane_n = '1;
                end
            end
            ST_WREC: begin
                r_d.state     = ST_IDLE;
                r_d.dq_oe     = 1'b0;
                r_d.rsp_valid = 1'b1;
            end
            ST_RACC: begin
                if (tmr_done) begin
                    r_d.state     = ST_IDLE;
                    r_d.rdata     = cap_word;
                    r_d.ce_n      = 1'b1;
                    r_d.oe_n      = 1'b1;
                    r_d.lane_n    = '1;
                    r_d.rsp_valid = 1'b1;
                    r_d.rd_turn   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.wdata     <= '0;
            r_q.be_n      <= '1;
            r_q.ce_n      <= 1'b1;
            r_q.we_n      <= 1'b1;
            r_q.oe_n      <= 1'b1;
            r_q.lane_n    <= '1;
            r_q.dq_oe     <= 1'b0;
            r_q.rdata     <= '0;
            r_q.rsp_valid <= 1'b0;
            r_q.rd_turn   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_rdata   = r_q.rdata;
    assign sram_addr   = r_q.addr;
    assign sram_dq_out = r_q.wdata;
    assign sram_dq_oe  = r_q.dq_oe;
    assign sram_ce_n   = r_q.ce_n;
    assign sram_we_n   = r_q.we_n;
    assign sram_oe_n   = r_q.oe_n;
    assign sram_lb_n   = r_q.lane_n[0];
    assign sram_ub_n   = r_q.lane_n[NLANE-1];
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_lb_n,
    input logic              sram_ub_n
);
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_addr != $past(sram_addr)) |->
        ($past(sram_ce_n) && $past(sram_we_n) && $past(sram_lb_n) && $past(sram_ub_n))); // R8

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n)); // R9

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> ($past(sram_oe_n) && $past(sram_oe_n, 2))); // R9

    AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R9

    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && !sram_ce_n)); // R3

    AST_LANE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_lb_n || !sram_ub_n) |-> !sram_ce_n); // R4

    AST_CE_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (!sram_lb_n || !sram_ub_n)); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R2
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
    localparam int CLK_PS = 10000;
    localparam int WP_PS = 12000, AW_PS = 8000, DW_PS = 6000;
    localparam int AA_PS = 25000, ACE_PS = 10000, OE_PS = 5000, BA_PS = 5000;

    function automatic int cdiv(input int t);
        return (t + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int mx(input int a, input int b);
        return a > b ? a : b;
    endfunction
    localparam int EXP_WP = mx(mx(mx(cdiv(WP_PS), cdiv(AW_PS)), cdiv(DW_PS)), 1);
    localparam int EXP_AA = mx(mx(mx(cdiv(AA_PS), cdiv(ACE_PS)), mx(cdiv(OE_PS), cdiv(BA_PS))), 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be_n = 2'b11;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] sram_addr;
    logic [15:0] sram_dq_out, sram_dq_in;
    logic sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;

    always #5 clk = ~clk;

    sram_ctrl #(
        .CLK_PS(CLK_PS), .T_WP_PS(WP_PS), .T_AW_PS(AW_PS), .T_DW_PS(DW_PS),
        .T_AA_PS(AA_PS), .T_ACE_PS(ACE_PS), .T_OE_PS(OE_PS), .T_BA_PS(BA_PS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be_n(req_be_n), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 40503) ^ 16'h5A5A;
    endfunction

    // bus-level RAM model and port monitor
    logic [15:0] ram [int];
    logic [15:0] ref_mem [int];
    logic [1:0]  cur_mask = 2'b11;
    bit   strobe_seen = 0;
    int   we_run = 0, oe_run = 0, oe_hi_run = 0;
    logic [16:0] m_addr = '0;
    bit   m_quiet = 1;
    logic m_dq_oe = 1'b0;

    function automatic logic [15:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : init_word(a);
    endfunction
    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    always @(negedge clk) begin
        logic [15:0] w;
        if (rst_n) begin
            if (sram_addr != m_addr)
                check(m_quiet, "R8", "address moved with a strobe low", 32'(sram_addr), 32'(m_addr));
            if (!sram_ce_n) strobe_seen = 1;
            if (!sram_we_n) begin
                we_run++;
                check(sram_lb_n == cur_mask[0] && sram_ub_n == cur_mask[1], "R4",
                      "lane strobes vs mask", {30'd0, sram_ub_n, sram_lb_n}, 32'(cur_mask));
                check(sram_oe_n, "R9", "output enable during write", 32'(sram_oe_n), 32'd1);
            end else if (we_run != 0) begin
                check(we_run == EXP_WP, "R3", "write strobe length", 32'(we_run), 32'(EXP_WP));
                we_run = 0;
            end
            if (!sram_oe_n) begin
                oe_run++;
            end else if (oe_run != 0) begin
                check(oe_run == EXP_AA, "R5", "read strobe length", 32'(oe_run), 32'(EXP_AA));
                oe_run = 0;
            end
            if (sram_dq_oe && !m_dq_oe)
                check(oe_hi_run >= 2, "R9", "turnaround before drive", 32'(oe_hi_run), 32'd2);
        end
        m_addr  = sram_addr;
        m_quiet = sram_ce_n && sram_we_n && sram_lb_n && sram_ub_n;
        m_dq_oe = sram_dq_oe;
        oe_hi_run = sram_oe_n ? oe_hi_run + 1 : 0;
        // writes into the model
        if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
            w = ram_rd(int'(sram_addr));
            if (!sram_lb_n) w[7:0]  = sram_dq_out[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq_out[15:8];
            ram[int'(sram_addr)] = w;
        end
        // read drive; disabled lanes carry a filler byte
        w = ram_rd(int'(sram_addr));
        sram_dq_in[7:0]  = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_lb_n) ? w[7:0]  : 8'hA5;
        sram_dq_in[15:8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_ub_n) ? w[15:8] : 8'hA5;
    end

    bit turn_pend = 0;

    task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        int lat, exp_lat;
        logic [15:0] exp_data, w;
        exp_data = '0;
        if (m == 2'b11) exp_lat = 0;
        else if (wr) exp_lat = EXP_WP + 2 + (turn_pend ? 1 : 0);
        else exp_lat = EXP_AA;
        if (!wr && m != 2'b11) begin
            w = ref_rd(int'(a));
            exp_data[7:0]  = m[0] ? 8'h00 : w[7:0];
            exp_data[15:8] = m[1] ? 8'h00 : w[15:8];
        end
        while (!req_ready) @(negedge clk);
        cur_mask = m; strobe_seen = 0;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be_n = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            check(!req_ready, "R2", "ready while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, wr ? (m == 2'b11 ? "R7" : "R3") : (m == 2'b11 ? "R7" : "R5"),
              "response latency", 32'(lat), 32'(exp_lat));
        if (wr) check(rsp_rdata == 16'h0, "R10", "write response data", 32'(rsp_rdata), 32'd0);
        else    check(rsp_rdata == exp_data, m == 2'b00 ? "R5" : "R6", "read data",
                      32'(rsp_rdata), 32'(exp_data));
        check(!req_ready, "R2", "ready during response", 32'(req_ready), 32'd0);
        @(negedge clk); #1;
        check(!rsp_valid, "R10", "response width", 32'(rsp_valid), 32'd0);
        if (m == 2'b11) check(!strobe_seen, "R7", "strobe toggled for empty mask",
                              32'(strobe_seen), 32'd0);
        if (wr && m != 2'b11) begin
            w = ref_rd(int'(a));
            if (!m[0]) w[7:0]  = d[7:0];
            if (!m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
            turn_pend = 0;
        end
        if (!wr && m != 2'b11) turn_pend = 1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not end");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n, "R1",
              "strobes in reset", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 32'h1f);
        check(!sram_dq_oe && req_ready && !rsp_valid, "R1", "bus/handshake in reset",
              {29'd0, sram_dq_oe, req_ready, rsp_valid}, 32'h2);
        rst_n = 1;
        @(negedge clk);
        check(!sram_dq_oe && req_ready && !rsp_valid && sram_ce_n, "R1", "state after reset",
              {29'd0, sram_dq_oe, req_ready, rsp_valid}, 32'h2);

        // directed corners
        do_req(1, 17'd5, 16'h1234, 2'b00);      // R3 full write
        do_req(0, 17'd5, 16'h0, 2'b00);         // R5 read back
        do_req(1, 17'd5, 16'hABCD, 2'b10);      // R4 lower lane only, after read (R9)
        do_req(0, 17'd5, 16'h0, 2'b00);         // expect 0x12CD
        do_req(1, 17'd5, 16'hEF99, 2'b01);      // R4 upper lane only
        do_req(0, 17'd5, 16'h0, 2'b10);         // R6 upper lane zeroed
        do_req(0, 17'd5, 16'h0, 2'b01);         // R6 lower lane zeroed
        do_req(1, 17'd6, 16'hFFFF, 2'b11);      // R7 empty write
        do_req(0, 17'd6, 16'h0, 2'b11);         // R7 empty read
        do_req(0, 17'd6, 16'h0, 2'b00);         // untouched word
        do_req(1, 17'h1FFFF, 16'h0F0F, 2'b00);  // top address
        do_req(1, 17'h00000, 16'hF0F0, 2'b00);  // back-to-back writes
        do_req(0, 17'h1FFFF, 16'h0, 2'b00);
        do_req(0, 17'h00000, 16'h0, 2'b00);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [16:0] a;
            r = int'($urandom % 10);
            a = (r < 8) ? 17'($urandom % 8) : (17'h1FFFE + 17'($urandom % 2));
            do_req(1'($urandom % 2), a, 16'($urandom), 2'($urandom));
        end
        finish_run();
    end
endmodule